// File: doc/BRIEF.md
# Victim Line Buffer with Swap

This block is a small, fully associative store that sits beside a direct-mapped first-level cache. It holds lines that the cache has thrown out. Each held line carries its block address, its data and a dirty flag. On every cache lookup the block address is also presented here and compared against every held entry in the same cycle. A match hands the line back to the cache, so a line that lost a set conflict gets a second chance without a trip to memory.

When the cache displaces a line during a matching lookup, the two lines trade places. The returned entry leaves the buffer and the displaced line takes over its slot. When the cache displaces a line with no match, the line goes into a free slot. If no slot is free, it replaces the least recently written entry. A dirty entry that is pushed out this way leaves through a writeback port with a valid/ready handshake. A clean one is simply discarded.

Recency is tracked with a small rank field per entry. Only insertions and swaps make an entry most recent. Callers must never insert a block address that is already held, unless that same address is being looked up in the same cycle.

Top module: `victim_buf`

## Requirements
- R1: After reset no entry is held: a lookup of any address reports no hit, `wb_valid` is low and `evict_ready` is high.
- R2: A line offered on the evict inputs while a slot is free is stored. A later lookup of its block address returns the same data and dirty flag.
- R3: `hit` rises in the same cycle as `lookup_valid`, combinationally, and only when the whole block address equals that of a held entry. `hit` is never high while `lookup_valid` is low.
- R4: A hit with no line offered on the evict inputs removes the entry at the following clock edge. A second lookup of that address misses.
- R5: A hit while a line is offered is a swap. The hit line is returned, and the offered line is stored in the slot just freed and becomes most recent. A swap never pushes another entry out and never loads the writeback port.
- R6: A line offered while all slots are full and there is no hit replaces the entry that was inserted or swapped in longest ago.
- R7: An entry pushed out by R6 appears on `wb_valid`/`wb_addr`/`wb_data` in the cycle after the edge that accepted the new line, but only if its dirty flag was 1. A clean entry produces no writeback.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_addr` and `wb_data` hold their values. The pending writeback is never lost.
- R9: `evict_ready` is low exactly when there is no hit, all slots are full, the least recent entry is dirty, `wb_valid` is high and `wb_ready` is low. An offer that is not accepted leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A cache lookup is presented this cycle |
| lookup_addr | input | ADDR_W | Block address of the lookup |
| hit | output | 1 | Lookup address matches a held entry |
| hit_data | output | DATA_W | Data of the matching entry |
| hit_dirty | output | 1 | Dirty flag of the matching entry |
| evict_valid | input | 1 | The cache offers a displaced line |
| evict_addr | input | ADDR_W | Block address of the offered line |
| evict_data | input | DATA_W | Data of the offered line |
| evict_dirty | input | 1 | Dirty flag of the offered line |
| evict_ready | output | 1 | The offered line is accepted at this edge |
| wb_valid | output | 1 | A dirty line awaits writeback |
| wb_addr | output | ADDR_W | Block address of the writeback line |
| wb_data | output | DATA_W | Data of the writeback line |
| wb_ready | input | 1 | Downstream takes the writeback line |

## Verification
Several properties are checked on every cycle:
- the rank field of each valid entry stays below the count of valid entries;
- a swap never loads the writeback port;
- a refused offer leaves the valid flags untouched;
- a hit always allows an offer;
- a returned entry is invalid after the edge;
- a stalled writeback holds steady.

Other properties depend on history and can only be shown by the bench's scenarios:
- which entry ends up replaced after a sequence of fills, swaps and removals;
- that the data and dirty flag come back intact;
- that clean victims vanish while dirty ones reach the port.

The bench runs these scenarios against a recency-ordered reference list, with backpressure on the writeback port.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DROP,
    ACT_SWAP,
    ACT_FILL,
    ACT_REPL,
    ACT_STALL
  } vb_act_e;
endpackage

// File: rtl/vbuf_match.sv
module vbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [DEPTH-1:0] cmp;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign cmp[g] = vld_i[g] && (tag_i[g] == addr_i);
  end

  always_comb begin
    idx_o = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (cmp[j]) idx_o = IDX_W'(j);
    end
  end

  assign hit_o = |cmp;
endmodule

// File: rtl/vbuf_lru.sv
module vbuf_lru #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld_i,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  output logic [IDX_W-1:0] victim_idx,
  output logic [IDX_W-1:0] free_idx,
  output logic             any_free
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0][IDX_W-1:0] age_q, age_d;
  logic [IDX_W-1:0] ref_age;

  // rank 0 = most recent; a fresh slot counts as the oldest rank
  always_comb begin
    ref_age = vld_i[touch_idx] ? age_q[touch_idx] : AGE_MAX;
    age_d   = age_q;
    if (touch_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (IDX_W'(j) == touch_idx)             age_d[j] = '0;
        else if (vld_i[j] && age_q[j] < ref_age) age_d[j] = age_q[j] + 1'b1;
      end
    end else if (drop_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (vld_i[j] && age_q[j] > age_q[drop_idx]) age_d[j] = age_q[j] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (touch_en || drop_en) age_q <= age_d;
  end

  always_comb begin
    victim_idx = '0;
    free_idx   = '0;
    any_free   = 1'b0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (vld_i[j] && age_q[j] == AGE_MAX) victim_idx = IDX_W'(j);
      if (!vld_i[j]) begin
        free_idx = IDX_W'(j);
        any_free = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    p_age_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      vld_i[g] |-> (int'(age_q[g]) < $countones(vld_i)));
  end
endmodule

// File: rtl/vbuf_wb.sv
module vbuf_wb #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              can_load_o
);
  logic valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign can_load_o = !valid_q || ready_i;

  always_comb begin
    valid_d = valid_q;
    if (load_i)                  valid_d = 1'b1;
    else if (valid_q && ready_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  p_wb_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              hit_dirty,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  output logic              evict_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q;
  logic [DEPTH-1:0]             drt_q;

  logic             match_hit, lk_hit;
  logic [IDX_W-1:0] hit_idx, victim_idx, free_idx, wr_idx;
  logic             any_free, wb_can_load, wb_load, wr_en;
  vb_act_e          act;

  vbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) match_i (
    .vld_i(vld_q), .tag_i(tag_q), .addr_i(lookup_addr),
    .hit_o(match_hit), .idx_o(hit_idx)
  );

  vbuf_lru #(.DEPTH(DEPTH)) lru_i (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_q),
    .touch_en(wr_en), .touch_idx(wr_idx),
    .drop_en(act == ACT_DROP), .drop_idx(hit_idx),
    .victim_idx(victim_idx), .free_idx(free_idx), .any_free(any_free)
  );

  vbuf_wb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wb_i (
    .clk(clk), .rst_n(rst_n), .load_i(wb_load),
    .addr_i(tag_q[victim_idx]), .data_i(dat_q[victim_idx]),
    .ready_i(wb_ready), .valid_o(wb_valid), .addr_o(wb_addr),
    .data_o(wb_data), .can_load_o(wb_can_load)
  );

  assign lk_hit    = lookup_valid && match_hit;
  assign hit       = lk_hit;
  assign hit_data  = dat_q[hit_idx];
  assign hit_dirty = drt_q[hit_idx];

  assign evict_ready = lk_hit || any_free || !drt_q[victim_idx] || wb_can_load;

  always_comb begin
    act = ACT_IDLE;
    if (lk_hit && evict_valid)  act = ACT_SWAP;
    else if (lk_hit)            act = ACT_DROP;
    else if (evict_valid) begin
      if (any_free)             act = ACT_FILL;
      else if (evict_ready)     act = ACT_REPL;
      else                      act = ACT_STALL;
    end
  end

  always_comb begin
    wr_en   = (act == ACT_SWAP) || (act == ACT_FILL) || (act == ACT_REPL);
    wb_load = (act == ACT_REPL) && drt_q[victim_idx];
    unique case (act)
      ACT_SWAP: wr_idx = hit_idx;
      ACT_FILL: wr_idx = free_idx;
      default:  wr_idx = victim_idx;
    endcase
    vld_d = vld_q;
    if (act == ACT_DROP) vld_d[hit_idx] = 1'b0;
    if (wr_en)           vld_d[wr_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= evict_addr;
      dat_q[wr_idx] <= evict_data;
      drt_q[wr_idx] <= evict_dirty;
    end
  end

  p_hit_gated_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> lookup_valid);
  p_drop_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP) |=> !vld_q[$past(hit_idx)]);
  p_swap_no_wb_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && evict_valid) |-> (!wb_load && evict_ready));
  p_stall_keeps_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_ready) |=> $stable(vld_q));
endmodule

// File: tb/victim_buf_tb_top.sv
`timescale 1ns/1ps
module victim_buf_tb_top;
  localparam int D  = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lookup_valid = 1'b0, evict_valid = 1'b0, evict_dirty = 1'b0, wb_ready = 1'b1;
  logic [AW-1:0] lookup_addr = '0, evict_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic hit, hit_dirty, evict_ready, wb_valid;
  logic [DW-1:0] hit_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #4 clk = ~clk;

  victim_buf #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .hit(hit), .hit_data(hit_data), .hit_dirty(hit_dirty),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .evict_dirty(evict_dirty), .evict_ready(evict_ready), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference: index 0 is most recent
  int m_n = 0;
  logic [AW-1:0] m_a[D];
  logic [DW-1:0] m_d[D];
  logic          m_y[D];
  logic          m_wbv = 1'b0;
  logic [AW-1:0] m_wba = '0;
  logic [DW-1:0] m_wbd = '0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int salt);
    return {a, a ^ 8'(salt * 37 + 5)};
  endfunction

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < m_n; i++) if (m_a[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic remove_at(input int p);
    for (int i = p; i < m_n - 1; i++) begin
      m_a[i] = m_a[i+1]; m_d[i] = m_d[i+1]; m_y[i] = m_y[i+1];
    end
    m_n--;
  endtask

  task automatic push_front(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic y);
    for (int i = m_n; i > 0; i--) begin
      m_a[i] = m_a[i-1]; m_d[i] = m_d[i-1]; m_y[i] = m_y[i-1];
    end
    m_a[0] = a; m_d[0] = d; m_y[0] = y; m_n++;
  endtask

  task automatic step(input bit lv, input logic [AW-1:0] la, input bit ev,
                      input logic [AW-1:0] ea, input logic [DW-1:0] ed, input bit ey, input bit wr);
    int  pos;
    bit  exp_rdy;
    @(negedge clk);
    lookup_valid = lv; lookup_addr = la;
    evict_valid = ev; evict_addr = ea; evict_data = ed; evict_dirty = ey;
    wb_ready = wr;
    #2;
    pos = lv ? find(la) : -1;
    chk(hit == (pos >= 0), "R3 hit", 32'(hit), 32'(pos >= 0));
    if (pos >= 0) begin
      chk(hit_data == m_d[pos], "R2 hit_data", 32'(hit_data), 32'(m_d[pos]));
      chk(hit_dirty == m_y[pos], "R2 hit_dirty", 32'(hit_dirty), 32'(m_y[pos]));
    end
    exp_rdy = (pos >= 0) || (m_n < D) || !m_y[D-1] || !m_wbv || wr;
    chk(evict_ready == exp_rdy, "R9 evict_ready", 32'(evict_ready), 32'(exp_rdy));
    chk(wb_valid == m_wbv, "R7 wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) begin
      chk(wb_addr == m_wba, "R8 wb_addr", 32'(wb_addr), 32'(m_wba));
      chk(wb_data == m_wbd, "R8 wb_data", 32'(wb_data), 32'(m_wbd));
    end
    @(posedge clk);
    if (m_wbv && wr) m_wbv = 1'b0;
    if (pos >= 0) begin
      remove_at(pos);
      if (ev) push_front(ea, ed, ey);
    end else if (ev && exp_rdy) begin
      if (m_n == D) begin
        if (m_y[D-1]) begin
          m_wbv = 1'b1; m_wba = m_a[D-1]; m_wbd = m_d[D-1];
        end
        m_n--;
      end
      push_front(ea, ed, ey);
    end
  endtask

  task automatic ins(input logic [AW-1:0] a, input bit y);
    step(1'b0, '0, 1'b1, a, pat(a, 1), y, 1'b1);
  endtask

  task automatic look(input logic [AW-1:0] a);
    step(1'b1, a, 1'b0, '0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset
    chk(wb_valid == 1'b0, "R1 wb_valid", 32'(wb_valid), 0);
    chk(evict_ready == 1'b1, "R1 evict_ready", 32'(evict_ready), 1);
    for (int a = 0; a < 256; a++) look(8'(a));
    // R2 fill, R6 clean replacement, R7 dirty writeback
    ins(8'd10, 1'b0); ins(8'd20, 1'b1); ins(8'd30, 1'b0); ins(8'd40, 1'b1);
    ins(8'd50, 1'b0);   // R6 replaces 10 (clean, no writeback)
    look(8'd10);        // R6 miss expected
    ins(8'd60, 1'b0);   // R7 replaces dirty 20
    // R5 swap: return 30, store 70
    step(1'b1, 8'd30, 1'b1, 8'd70, pat(8'd70, 2), 1'b1, 1'b1);
    look(8'd30);        // R5 gone
    ins(8'd80, 1'b0);   // R6 replaces 40 dirty
    ins(8'd90, 1'b1);   // R6 replaces 50 clean
    // R4 removal then second lookup misses
    look(8'd60); look(8'd60);
    ins(8'd100, 1'b1);  // R2 into freed slot, no writeback
    // R8/R9 backpressure: fill dirty with writeback stalled
    for (int k = 0; k < 8; k++)
      step(1'b0, '0, 1'b1, 8'(120 + k), pat(8'(120 + k), 3), 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) look(8'(120 + k)); // R9 refused lines absent
    // mixed sweep over a small address pool
    lfsr = 16'hACE1;
    for (int s = 0; s < 3000; s++) begin
      logic [AW-1:0] la, ea;
      bit lv, ev, ey, wr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      la = 8'(lfsr[3:0] % 10);
      ea = 8'(lfsr[7:4] % 10);
      lv = lfsr[8]; ev = lfsr[9] | lfsr[10]; ey = lfsr[11]; wr = lfsr[12] | lfsr[13];
      if (ev && find(ea) >= 0 && !(lv && la == ea)) ev = 1'b0;
      step(lv, la, ev, ea, pat(ea, s), ey, wr);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule